// File: doc/BRIEF.md
# Dual-Mode Converter Reset Sequencer

This block drives the active-low reset line of an external data converter. It then keeps every later access blocked until the converter can take one. After system reset it holds the converter in reset. Supply monitoring is done elsewhere; once the power-good input has been high for a programmed number of cycles, the block runs a long (full) reset sequence. After that first release, a request input starts a new sequence, and a type bit selects a short (partial) or a long (full) reset.

Each reset type has its own set of cycle counts: the minimum low time, the setup window in which the configuration-strap outputs must not move before release, the hold window after release, the delay before a write is allowed, and the delay before a conversion may start. The strap outputs follow the strap inputs only while the sequencer is idle or waiting for power. They freeze when a sequence starts. The write-ready and conversion-ready flags drop when reset asserts and each rises on its own delay. A request that arrives while a sequence runs is stored and served once the running sequence ends. A stored full request wins over a stored partial one.

All times are cycle counts set by parameters. With the reset values they match a 200 MHz clock.

Top module: `conv_reset_seq`

## Requirements
- R1: After `rst_n` is released, `dev_rst_n`, `write_ready` and `conv_ready` stay low until `pwr_good`, seen through a SYNC_STAGES-flop synchroniser, has been high on PWR_WAIT consecutive clock edges. Any low sample restarts that count.
- R2: The first release after the power wait uses full timing. The reset stays low for max(FULL_LOW, FULL_SETUP) more cycles. Recovery then uses the full write and conversion delays.
- R3: A request sampled with `req_valid`=1 and `req_full`=0 while idle drives `dev_rst_n` low from the next cycle for exactly max(PART_LOW, PART_SETUP) cycles.
- R4: A request sampled with `req_valid`=1 and `req_full`=1 while idle drives `dev_rst_n` low from the next cycle for exactly max(FULL_LOW, FULL_SETUP) cycles.
- R5: `write_ready` and `conv_ready` are both low in every cycle in which `dev_rst_n` is low.
- R6: Counting the first high cycle of `dev_rst_n` as cycle 0, `write_ready` first rises in cycle PART_WR or FULL_WR and `conv_ready` in cycle PART_CONV or FULL_CONV, each according to the reset type.
- R7: `strap_out` keeps the value `strap_in` had at the edge that started the sequence. It holds that value through the low phase and for at least the type's hold count after release, whatever `strap_in` does.
- R8: While idle or waiting for power, `strap_out` shows, one cycle later, the value of `strap_in`.
- R9: Requests sampled during a running sequence are stored and collapse into exactly one further sequence. That sequence starts after one idle cycle and is full if any stored request was full, otherwise partial.
- R10: Once a ready flag is high, it stays high until `dev_rst_n` next falls.
- R11: After the first release, `pwr_good` has no effect. Dropping it while idle leaves `dev_rst_n` and both ready flags high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| pwr_good | input | 1 | Supplies-stable indication, asynchronous |
| req_valid | input | 1 | Reset request strobe, one cycle per request |
| req_full | input | 1 | Request type: 1 full, 0 partial |
| strap_in | input | STRAP_W | Desired configuration-strap levels |
| dev_rst_n | output | 1 | Active-low reset to the converter |
| strap_out | output | STRAP_W | Strap levels presented to the converter |
| conv_ready | output | 1 | Conversion may be started |
| write_ready | output | 1 | Register write may be issued |

## Verification
The hardest case to reach is a stored request that has to be merged with others. Requests must land in different phases of a running sequence: during the low pulse, and late in the release phase after the write flag is already high. A partial request and a full request must also arrive in either order. The bench places its strobes at fixed offsets inside a running sequence. It measures the width of every low pulse at the ports, which shows whether exactly one extra sequence of the right type follows. A cycle model in the bench is compared against every output on every clock. That comparison also covers the single idle cycle between the two sequences.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

   typedef enum logic [1:0] {
      PH_PWR  = 2'd0,
      PH_LOW  = 2'd1,
      PH_REL  = 2'd2,
      PH_IDLE = 2'd3
   } rseq_phase_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_flops
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= STAGES'({sh, d});
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rseq_req_latch.sv
module rseq_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic take_i,
   input  logic req_valid,
   input  logic req_full,
   output logic pend_any,
   output logic pend_full
);
   always_ff @(posedge clk) begin
      if (!rst_n || take_i) begin
         pend_any  <= 1'b0;
         pend_full <= 1'b0;
      end else if (open_i && req_valid) begin
         pend_any <= 1'b1;
         if (req_full) pend_full <= 1'b1;
      end
   end

   // R9: a stored request survives until it is served
   assert_pend_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_any && !take_i |=> pend_any);
endmodule

// File: rtl/rseq_strap_reg.sv
module rseq_strap_reg #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         track_i,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)       q <= '0;
      else if (track_i) q <= d;
   end
endmodule

// File: rtl/conv_reset_seq.sv
module conv_reset_seq
   import rseq_pkg::*;
#(
   parameter int unsigned STRAP_W      = 4,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned PWR_WAIT     = 200000,
   parameter int unsigned PART_LOW     = 20,
   parameter int unsigned PART_LOW_MAX = 100,
   parameter int unsigned FULL_LOW     = 240,
   parameter int unsigned PART_SETUP   = 2,
   parameter int unsigned FULL_SETUP   = 10000,
   parameter int unsigned PART_HOLD    = 2,
   parameter int unsigned FULL_HOLD    = 48000,
   parameter int unsigned PART_WR      = 10,
   parameter int unsigned FULL_WR      = 48000,
   parameter int unsigned PART_CONV    = 24,
   parameter int unsigned FULL_CONV    = 3000000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwr_good,
   input  logic               req_valid,
   input  logic               req_full,
   input  logic [STRAP_W-1:0] strap_in,
   output logic               dev_rst_n,
   output logic [STRAP_W-1:0] strap_out,
   output logic               conv_ready,
   output logic               write_ready
);
   localparam int unsigned P_LOWLEN = umax(PART_LOW, PART_SETUP);
   localparam int unsigned F_LOWLEN = umax(FULL_LOW, FULL_SETUP);
   localparam int unsigned P_DONE   = umax(PART_HOLD, umax(PART_WR, PART_CONV));
   localparam int unsigned F_DONE   = umax(FULL_HOLD, umax(FULL_WR, FULL_CONV));
   localparam int unsigned CNT_MAX  = umax(umax(PWR_WAIT, F_LOWLEN),
                                           umax(umax(P_LOWLEN, P_DONE), F_DONE));
   localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

   generate
      if (PWR_WAIT == 0 || PART_LOW == 0 || FULL_LOW == 0 || PART_HOLD == 0 ||
          FULL_HOLD == 0 || PART_WR == 0 || FULL_WR == 0 || PART_CONV == 0 ||
          FULL_CONV == 0) begin : g_bad_zero
         $error("conv_reset_seq: every cycle count must be at least one");
      end
      if (P_LOWLEN > PART_LOW_MAX) begin : g_bad_part_low
         $error("conv_reset_seq: partial low pulse exceeds its upper bound");
      end
      if (FULL_LOW < PART_LOW) begin : g_bad_order
         $error("conv_reset_seq: full low time shorter than partial low time");
      end
      if (STRAP_W == 0) begin : g_bad_width
         $error("conv_reset_seq: strap width must be nonzero");
      end
   endgenerate

   rseq_phase_e      phase;
   logic [CNT_W-1:0] cnt;
   logic             full_q;
   logic             pg_s;
   logic             pend_any, pend_full;
   logic             start, start_full;
   logic [CNT_W-1:0] low_last, done_last, wr_lim, cv_lim;

   rseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pwr_good), .q(pg_s));

   assign start      = (phase == PH_IDLE) && (req_valid || pend_any);
   assign start_full = pend_full || (req_valid && req_full);

   rseq_req_latch u_latch (
      .clk(clk), .rst_n(rst_n),
      .open_i(phase != PH_IDLE), .take_i(start),
      .req_valid(req_valid), .req_full(req_full),
      .pend_any(pend_any), .pend_full(pend_full));

   rseq_strap_reg #(.W(STRAP_W)) u_strap (
      .clk(clk), .rst_n(rst_n),
      .track_i(phase == PH_IDLE || phase == PH_PWR),
      .d(strap_in), .q(strap_out));

   always_comb begin
      low_last  = full_q ? CNT_W'(F_LOWLEN - 1) : CNT_W'(P_LOWLEN - 1);
      done_last = full_q ? CNT_W'(F_DONE - 1)   : CNT_W'(P_DONE - 1);
      wr_lim    = full_q ? CNT_W'(FULL_WR)      : CNT_W'(PART_WR);
      cv_lim    = full_q ? CNT_W'(FULL_CONV)    : CNT_W'(PART_CONV);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase  <= PH_PWR;
         cnt    <= '0;
         full_q <= 1'b1;
      end else begin
         case (phase)
            PH_PWR: begin
               if (!pg_s) cnt <= '0;
               else if (cnt == CNT_W'(PWR_WAIT - 1)) begin
                  phase  <= PH_LOW;
                  cnt    <= '0;
                  full_q <= 1'b1;
               end else cnt <= cnt + 1'b1;
            end
            PH_LOW: begin
               if (cnt == low_last) begin
                  phase <= PH_REL;
                  cnt   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_REL: begin
               if (cnt == done_last) begin
                  phase <= PH_IDLE;
                  cnt   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            PH_IDLE: begin
               if (start) begin
                  phase  <= PH_LOW;
                  cnt    <= '0;
                  full_q <= start_full;
               end
            end
            default: phase <= PH_PWR;
         endcase
      end
   end

   assign dev_rst_n   = (phase == PH_REL) || (phase == PH_IDLE);
   assign write_ready = (phase == PH_IDLE) || ((phase == PH_REL) && (cnt >= wr_lim));
   assign conv_ready  = (phase == PH_IDLE) || ((phase == PH_REL) && (cnt >= cv_lim));

   // R1: reset held while the synchronised power-good is low
   assert_power_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PWR) && !pg_s |=> (phase == PH_PWR) && !dev_rst_n);

   // R5: no ready flag while the converter sits in reset
   assert_ready_low_in_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_rst_n |-> !write_ready && !conv_ready);

   // R7: straps do not move on the release edge
   assert_strap_stable_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_rst_n) |-> $stable(strap_out));

   // R10: ready flags only fall together with the reset line
   assert_write_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      write_ready |=> write_ready || !dev_rst_n);
   assert_conv_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      conv_ready |=> conv_ready || !dev_rst_n);

   // R11: the power wait is never re-entered once left
   assert_no_power_revisit_R11: assert property (@(posedge clk) disable iff (!rst_n)
      phase != PH_PWR |=> phase != PH_PWR);

endmodule

// File: tb/conv_reset_seq_test.sv
`timescale 1ns/1ps
module conv_reset_seq_test;
   localparam int T_PWR   = 20;
   localparam int T_PLOW  = 8;
   localparam int T_FLOW  = 12;
   localparam int T_PSET  = 3;
   localparam int T_FSET  = 16;
   localparam int T_PHOLD = 2;
   localparam int T_FHOLD = 9;
   localparam int T_PWR_D = 4;
   localparam int T_FWR_D = 20;
   localparam int T_PCV   = 6;
   localparam int T_FCV   = 30;
   localparam int W       = 4;

   localparam int E_PLOW  = (T_PLOW > T_PSET) ? T_PLOW : T_PSET;
   localparam int E_FLOW  = (T_FLOW > T_FSET) ? T_FLOW : T_FSET;
   localparam int E_PEND  = (T_PHOLD > T_PWR_D) ? ((T_PHOLD > T_PCV) ? T_PHOLD : T_PCV)
                                                : ((T_PWR_D > T_PCV) ? T_PWR_D : T_PCV);
   localparam int E_FEND  = (T_FHOLD > T_FWR_D) ? ((T_FHOLD > T_FCV) ? T_FHOLD : T_FCV)
                                                : ((T_FWR_D > T_FCV) ? T_FWR_D : T_FCV);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b0;
   logic req_valid = 1'b0;
   logic req_full = 1'b0;
   logic [W-1:0] strap_in = '0;
   logic dev_rst_n, conv_ready, write_ready;
   logic [W-1:0] strap_out;

   always #2.5 clk = ~clk;

   conv_reset_seq #(
      .STRAP_W(W), .SYNC_STAGES(2), .PWR_WAIT(T_PWR),
      .PART_LOW(T_PLOW), .PART_LOW_MAX(100), .FULL_LOW(T_FLOW),
      .PART_SETUP(T_PSET), .FULL_SETUP(T_FSET),
      .PART_HOLD(T_PHOLD), .FULL_HOLD(T_FHOLD),
      .PART_WR(T_PWR_D), .FULL_WR(T_FWR_D),
      .PART_CONV(T_PCV), .FULL_CONV(T_FCV)
   ) uut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
      .req_valid(req_valid), .req_full(req_full), .strap_in(strap_in),
      .dev_rst_n(dev_rst_n), .strap_out(strap_out),
      .conv_ready(conv_ready), .write_ready(write_ready));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural model: phase 0 power wait, 1 low, 2 released, 3 idle
   int m_ph = 0, m_age = 0, m_queued = 0;
   bit m_full = 1;
   bit [1:0] m_pg = '0;
   logic [W-1:0] m_strap = '0;
   bit model_on = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_age = 0; m_queued = 0; m_full = 1; m_pg = '0; m_strap = '0;
      end else begin
         model_on = 1;
         if (m_ph == 0 || m_ph == 3) m_strap = strap_in;
         if (m_ph != 3 && req_valid) begin
            if (req_full) m_queued = 2;
            else if (m_queued == 0) m_queued = 1;
         end
         if (m_ph == 0) begin
            if (!m_pg[1]) m_age = 0;
            else if (m_age + 1 == T_PWR) begin m_ph = 1; m_age = 0; m_full = 1; end
            else m_age++;
         end else if (m_ph == 1) begin
            if (m_age + 1 == (m_full ? E_FLOW : E_PLOW)) begin m_ph = 2; m_age = 0; end
            else m_age++;
         end else if (m_ph == 2) begin
            if (m_age + 1 == (m_full ? E_FEND : E_PEND)) begin m_ph = 3; m_age = 0; end
            else m_age++;
         end else if (req_valid || m_queued != 0) begin
            m_full = (m_queued == 2) || (req_valid && req_full);
            m_queued = 0; m_ph = 1; m_age = 0;
         end
         m_pg = {m_pg[0], pwr_good};
      end
   end

   always @(negedge clk) begin
      if (rst_n && model_on) begin
         bit e_rst, e_wr, e_cv;
         e_rst = (m_ph >= 2);
         e_wr = (m_ph == 3) || (m_ph == 2 && m_age >= (m_full ? T_FWR_D : T_PWR_D));
         e_cv = (m_ph == 3) || (m_ph == 2 && m_age >= (m_full ? T_FCV : T_PCV));
         check(dev_rst_n == e_rst, "R1 R2 R3 R4 R9 reset line", dev_rst_n, e_rst);
         check(write_ready == e_wr, "R6 R10 write_ready", write_ready, e_wr);
         check(conv_ready == e_cv, "R6 R10 conv_ready", conv_ready, e_cv);
         check(strap_out == m_strap, "R7 R8 strap_out", strap_out, m_strap);
      end
   end

   // port-level measurements
   int widths[$];
   int wrd[$];
   int cvd[$];
   int low_run = 0, since = 0, r5_bad = 0;
   bit prev_rst = 0, wr_seen = 0, cv_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!dev_rst_n) begin
            low_run++;
            if (write_ready || conv_ready) r5_bad++;
         end else begin
            if (!prev_rst) begin
               widths.push_back(low_run);
               low_run = 0; since = 0; wr_seen = 0; cv_seen = 0;
            end
            if (write_ready && !wr_seen) begin wrd.push_back(since); wr_seen = 1; end
            if (conv_ready && !cv_seen) begin cvd.push_back(since); cv_seen = 1; end
            since++;
         end
         prev_rst = dev_rst_n;
      end
   end

   task automatic do_req(input bit full);
      @(negedge clk); req_valid = 1'b1; req_full = full;
      @(negedge clk); req_valid = 1'b0; req_full = 1'b0;
   endtask

   task automatic wait_quiet();
      int run = 0;
      for (int i = 0; i < 500 && run < 4; i++) begin
         @(negedge clk);
         if (write_ready && conv_ready && dev_rst_n) run++;
         else run = 0;
      end
   endtask

   task automatic clear_meas();
      widths.delete(); wrd.delete(); cvd.delete();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      check(dev_rst_n == 1'b0, "R1 dev_rst_n in reset", dev_rst_n, 0);
      check(write_ready == 1'b0 && conv_ready == 1'b0, "R1 ready in reset",
            write_ready + conv_ready, 0);
      rst_n = 1'b1;
      strap_in = 4'h3;
      pwr_good = 1'b1;
      repeat (10) @(negedge clk);
      pwr_good = 1'b0;
      repeat (2) @(negedge clk);
      pwr_good = 1'b1;
      repeat (15) @(negedge clk);
      check(dev_rst_n == 1'b0, "R1 power-good glitch restarts wait", dev_rst_n, 0);
      wait_quiet();
      check(wrd.size() == 1 && wrd[0] == T_FWR_D, "R2 R6 power-up write delay",
            (wrd.size() > 0) ? wrd[0] : -1, T_FWR_D);
      check(cvd.size() == 1 && cvd[0] == T_FCV, "R2 R6 power-up conv delay",
            (cvd.size() > 0) ? cvd[0] : -1, T_FCV);

      // R8: idle tracking
      strap_in = 4'hA;
      @(negedge clk);
      check(strap_out == 4'hA, "R8 idle strap tracking", strap_out, 4'hA);

      // R11: power-good ignored after release
      pwr_good = 1'b0;
      repeat (6) @(negedge clk);
      check(dev_rst_n && write_ready && conv_ready, "R11 pwr_good drop ignored",
            dev_rst_n + write_ready + conv_ready, 3);
      pwr_good = 1'b1;

      // R3 R6 R7: partial request with strap change mid-sequence
      clear_meas();
      strap_in = 4'h5;
      do_req(1'b0);
      strap_in = 4'hC;
      repeat (3) @(negedge clk);
      check(strap_out == 4'h5 && !dev_rst_n, "R7 strap frozen during low", strap_out, 4'h5);
      wait_quiet();
      check(widths.size() == 1 && widths[0] == E_PLOW, "R3 partial low width",
            (widths.size() > 0) ? widths[0] : -1, E_PLOW);
      check(wrd.size() == 1 && wrd[0] == T_PWR_D, "R6 partial write delay",
            (wrd.size() > 0) ? wrd[0] : -1, T_PWR_D);
      check(cvd.size() == 1 && cvd[0] == T_PCV, "R6 partial conv delay",
            (cvd.size() > 0) ? cvd[0] : -1, T_PCV);
      check(strap_out == 4'hC, "R8 strap follows after sequence", strap_out, 4'hC);

      // R4 R6: full request
      clear_meas();
      do_req(1'b1);
      wait_quiet();
      check(widths.size() == 1 && widths[0] == E_FLOW, "R4 full low width",
            (widths.size() > 0) ? widths[0] : -1, E_FLOW);
      check(wrd.size() == 1 && wrd[0] == T_FWR_D, "R6 full write delay",
            (wrd.size() > 0) ? wrd[0] : -1, T_FWR_D);
      check(cvd.size() == 1 && cvd[0] == T_FCV, "R6 full conv delay",
            (cvd.size() > 0) ? cvd[0] : -1, T_FCV);

      // R9: two partial requests stored collapse into one partial
      clear_meas();
      do_req(1'b0);
      repeat (2) @(negedge clk);
      do_req(1'b0);
      repeat (3) @(negedge clk);
      do_req(1'b0);
      wait_quiet();
      check(widths.size() == 2, "R9 stored partials give one extra sequence", widths.size(), 2);
      check(widths.size() == 2 && widths[1] == E_PLOW, "R9 extra sequence is partial",
            (widths.size() > 1) ? widths[1] : -1, E_PLOW);

      // R9: stored full wins over stored partial
      clear_meas();
      do_req(1'b0);
      repeat (2) @(negedge clk);
      do_req(1'b1);
      repeat (2) @(negedge clk);
      do_req(1'b0);
      wait_quiet();
      check(widths.size() == 2 && widths[0] == E_PLOW && widths[1] == E_FLOW,
            "R9 full priority", (widths.size() > 1) ? widths[1] : -1, E_FLOW);

      // R9: partial stored late in a full release phase
      clear_meas();
      do_req(1'b1);
      repeat (E_FLOW + T_FWR_D) @(negedge clk);
      do_req(1'b0);
      wait_quiet();
      check(widths.size() == 2 && widths[0] == E_FLOW && widths[1] == E_PLOW,
            "R9 late partial served", (widths.size() > 1) ? widths[1] : -1, E_PLOW);

      // R5: no ready while reset low, over the whole run
      check(r5_bad == 0, "R5 ready while reset low", r5_bad, 0);

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule